// File: doc/BRIEF.md
# Echo Envelope Detector with 2:1 Decimation

This block turns a stream of signed, bandpass-filtered echo samples into an unsigned envelope value. Each accepted sample is rectified to its magnitude and then smoothed by a first-order recursive lowpass filter. The filter's smoothing strength is set by a 4-bit shift amount. Samples arrive with a valid strobe at ten times the burst frequency. The block publishes every second filter result, so the output updates at five times the burst frequency.

Each new output sets a sticky ready flag. Software clears the flag by reading the output or by pulsing an acknowledge strobe. The flag drives an interrupt line only while the interrupt enable is high. A synchronous clear input returns the filter, the pairing phase, the output and the flag to zero without a full reset. This lets a new echo measurement start from a clean state.

Top module: `envd_top`

## Requirements
- R1: For each accepted sample (`smp_vld` high), the magnitude fed to the filter is the absolute value of the two's complement `smp_data`. With `shift_k` = 0, the published output equals the magnitude of the second sample of each pair.
- R2: The sample value -32768 (0x8000) rectifies to 32767 (0x7FFF) rather than wrapping.
- R3: On each accepted sample the filter state y is updated as y ← y + floor((m − y) / 2^k). Here m is the magnitude and k is `shift_k`, taken as an unsigned value from 0 to 15.
- R4: Accepted samples are counted in pairs from reset or clear. `env_data` takes the new filter state only in the cycle after the second sample of a pair is accepted, and it holds its value at all other times. Cycles without `smp_vld` do not advance the pairing.
- R5: `env_rdy` is 1 in the cycle after the second sample of a pair is accepted.
- R6: A high `rd_strobe` or `ack_w1c` clears `env_rdy` on the next clock edge. If a pair completes in the same cycle, the flag is set instead.
- R7: `env_irq` is high exactly when `env_rdy` and `irq_en` are both high.
- R8: A high `clr` at a clock edge zeroes the filter state, the pairing phase, `env_data` and `env_rdy`. This takes priority over any sample in the same cycle.
- R9: While `rst_n` is low, `env_data`, `env_rdy` and `env_irq` are 0.
- R10: `env_data` never exceeds 32767; its top bit is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of filter, phase, output and flag |
| smp_vld | input | 1 | Input sample strobe |
| smp_data | input | 16 | Signed two's complement sample |
| shift_k | input | 4 | Filter shift amount k |
| rd_strobe | input | 1 | Output register read, clears ready |
| ack_w1c | input | 1 | Write-one-to-clear of ready |
| irq_en | input | 1 | Interrupt enable |
| env_data | output | 16 | Unsigned envelope output |
| env_rdy | output | 1 | Sticky data-ready flag |
| env_irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a collision: a clearing read or acknowledge lands in the very cycle that a pair completes. The completion cycle depends on how many valid strobes have been accepted since the last clear, and idle gaps do not count. The stimulus therefore tracks the pairing parity itself and fires `rd_strobe` and `ack_w1c` exactly on second samples. It also fires them on first samples and on idle cycles. The clear is additionally pulsed in the middle of a pair, to show that the pairing restarts from the next accepted sample.

// File: rtl/envd_pkg.sv
package envd_pkg;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;

endpackage

// File: rtl/envd_rectify.sv
module envd_rectify #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] x,
  output logic [DATA_W-1:0] mag
);
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

  always_comb begin
    if (x == MIN_NEG) begin
      mag = MAX_POS;
    end else if (x[DATA_W-1]) begin
      mag = (~x) + 1'b1;
    end else begin
      mag = x;
    end
  end
endmodule

// File: rtl/envd_lpf.sv
module envd_lpf #(
  parameter int DATA_W = 16,
  parameter int K_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] mag,
  input  logic [K_W-1:0]    k,
  output logic [DATA_W-1:0] y_nxt,
  output logic [DATA_W-1:0] y_q
);
  localparam int EXT_W = DATA_W + 2;

  logic signed [EXT_W-1:0] diff;
  logic signed [EXT_W-1:0] step;
  logic signed [EXT_W-1:0] sum;
  logic [DATA_W-1:0]       y_d;

  always_comb begin
    diff  = $signed({2'b00, mag}) - $signed({2'b00, y_q});
    step  = diff >>> k;
    sum   = $signed({2'b00, y_q}) + step;
    y_nxt = sum[DATA_W-1:0];
    if (clr) begin
      y_d = '0;
    end else if (en) begin
      y_d = y_nxt;
    end else begin
      y_d = y_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else begin
      y_q <= y_d;
    end
  end
endmodule

// File: rtl/envd_decim.sv
module envd_decim
  import envd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] y_nxt,
  output logic [DATA_W-1:0] out_q,
  output phase_e            phase_q,
  output logic              done
);
  phase_e            phase_d;
  logic [DATA_W-1:0] out_d;

  always_comb begin
    done    = en && (phase_q == PH_SECOND) && !clr;
    phase_d = phase_q;
    out_d   = out_q;
    if (clr) begin
      phase_d = PH_FIRST;
      out_d   = '0;
    end else if (en) begin
      phase_d = (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
      if (phase_q == PH_SECOND) begin
        out_d = y_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
      out_q   <= '0;
    end else begin
      phase_q <= phase_d;
      out_q   <= out_d;
    end
  end
endmodule

// File: rtl/envd_flag.sv
module envd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  input  logic rd,
  input  logic ack,
  input  logic irq_en,
  output logic rdy_q,
  output logic irq
);
  logic rdy_d;

  always_comb begin
    if (clr) begin
      rdy_d = 1'b0;
    end else if (set) begin
      rdy_d = 1'b1;
    end else if (rd || ack) begin
      rdy_d = 1'b0;
    end else begin
      rdy_d = rdy_q;
    end
    irq = rdy_q && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
    end
  end
endmodule

// File: rtl/envd_top.sv
module envd_top
  import envd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int K_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [K_W-1:0]    shift_k,
  input  logic              rd_strobe,
  input  logic              ack_w1c,
  input  logic              irq_en,
  output logic [DATA_W-1:0] env_data,
  output logic              env_rdy,
  output logic              env_irq
);
  logic [DATA_W-1:0] mag;
  logic [DATA_W-1:0] y_nxt;
  logic [DATA_W-1:0] y_q;
  phase_e            phase_q;
  logic              pair_done;

  envd_rectify #(.DATA_W(DATA_W)) u_rect (
    .x   (smp_data),
    .mag (mag)
  );

  envd_lpf #(.DATA_W(DATA_W), .K_W(K_W)) u_lpf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .en    (smp_vld),
    .mag   (mag),
    .k     (shift_k),
    .y_nxt (y_nxt),
    .y_q   (y_q)
  );

  envd_decim #(.DATA_W(DATA_W)) u_decim (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .en      (smp_vld),
    .y_nxt   (y_nxt),
    .out_q   (env_data),
    .phase_q (phase_q),
    .done    (pair_done)
  );

  envd_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .set    (pair_done),
    .rd     (rd_strobe),
    .ack    (ack_w1c),
    .irq_en (irq_en),
    .rdy_q  (env_rdy),
    .irq    (env_irq)
  );
endmodule

// File: rtl/envd_checker.sv
module envd_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              smp_vld,
  input logic              phase,
  input logic              rd_strobe,
  input logic              ack_w1c,
  input logic              irq_en,
  input logic [DATA_W-1:0] env_data,
  input logic              env_rdy,
  input logic              env_irq
);
  // R10
  a_r10_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    env_data[DATA_W-1] == 1'b0);

  // R5, R6: completion sets the flag even against a clearing read
  a_r5_set_on_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && phase && !clr) |=> env_rdy);

  // R6
  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_strobe || ack_w1c) && !(smp_vld && phase)) |=> !env_rdy);

  // R4
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !clr) |=> $stable(env_data));

  // R4
  a_r4_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !phase && !clr) |=> $stable(env_data));

  // R7
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    env_irq |-> (irq_en && env_rdy));

  // R8
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!env_rdy && env_data == '0));

  // R9
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r9_reset: assert (env_data == '0 && !env_rdy && !env_irq);
    end
  end
endmodule

bind envd_top envd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .smp_vld   (smp_vld),
  .phase     (phase_q),
  .rd_strobe (rd_strobe),
  .ack_w1c   (ack_w1c),
  .irq_en    (irq_en),
  .env_data  (env_data),
  .env_rdy   (env_rdy),
  .env_irq   (env_irq)
);

// File: tb/envd_top_test.sv
`timescale 1ns/1ps
module envd_top_test;
  logic        clk;
  logic        rst_n;
  logic        clr;
  logic        smp_vld;
  logic [15:0] smp_data;
  logic [3:0]  shift_k;
  logic        rd_strobe;
  logic        ack_w1c;
  logic        irq_en;
  logic [15:0] env_data;
  logic        env_rdy;
  logic        env_irq;

  int tests_run;
  int tests_failed;
  int cycles;
  bit finished;

  // behavioural reference state
  int m_y;
  int m_ph;
  int m_out;
  int m_rdy;

  envd_top uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .smp_vld   (smp_vld),
    .smp_data  (smp_data),
    .shift_k   (shift_k),
    .rd_strobe (rd_strobe),
    .ack_w1c   (ack_w1c),
    .irq_en    (irq_en),
    .env_data  (env_data),
    .env_rdy   (env_rdy),
    .env_irq   (env_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int magnitude(input logic [15:0] v);
    int s;
    s = $signed(v);
    if (s == -32768) return 32767;   // R2
    if (s < 0) return -s;            // R1
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model update and per-cycle comparison
  always @(posedge clk) begin
    int d;
    bit done;
    if (!rst_n) begin
      m_y = 0; m_ph = 0; m_out = 0; m_rdy = 0;
    end else if (clr) begin           // R8
      m_y = 0; m_ph = 0; m_out = 0; m_rdy = 0;
    end else begin
      done = 0;
      if (smp_vld) begin
        d = magnitude(smp_data) - m_y;
        m_y = m_y + (d >>> shift_k);  // R3
        if (m_ph == 1) begin          // R4
          m_out = m_y;
          done = 1;
        end
        m_ph = 1 - m_ph;
      end
      if (done) m_rdy = 1;            // R5, set wins (R6)
      else if (rd_strobe || ack_w1c) m_rdy = 0;
    end
    #1;
    if (rst_n && !finished) begin
      check(env_data == m_out[15:0], "R3 R4 env_data", env_data, m_out);
      check(env_rdy == m_rdy[0], "R5 R6 env_rdy", env_rdy, m_rdy);
      check(env_irq == (m_rdy[0] && irq_en), "R7 env_irq", env_irq, m_rdy[0] && irq_en);
      check(env_data[15] == 1'b0, "R10 msb", env_data[15], 0);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_vld = 0; rd_strobe = 0; ack_w1c = 0; clr = 0;
    end
  endtask

  task automatic push(input logic [15:0] v);
    @(negedge clk);
    smp_vld = 1; smp_data = v; rd_strobe = 0; ack_w1c = 0; clr = 0;
  endtask

  task automatic do_clr();
    @(negedge clk);
    smp_vld = 0; rd_strobe = 0; ack_w1c = 0; clr = 1;
  endtask

  initial begin
    int ph;
    tests_run = 0; tests_failed = 0; cycles = 0; finished = 0;
    rst_n = 0; clr = 0; smp_vld = 0; smp_data = '0; shift_k = '0;
    rd_strobe = 0; ack_w1c = 0; irq_en = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(env_data == 0 && !env_rdy && !env_irq, "R9 reset", env_data, 0);
    rst_n = 1;

    // R1: k=0 passes magnitude of second sample
    shift_k = 0;
    push(16'd100); push(-16'sd1234); idle(1);
    check(env_data == 16'd1234, "R1 abs", env_data, 1234);
    // R2: most negative value saturates
    push(16'd5); push(16'h8000); idle(1);
    check(env_data == 16'd32767, "R2 saturate", env_data, 32767);
    // R7: interrupt follows enable
    irq_en = 1; idle(1);
    check(env_irq == 1'b1, "R7 irq on", env_irq, 1);
    // R6: read clears
    @(negedge clk); rd_strobe = 1; idle(1);
    check(env_rdy == 1'b0, "R6 read clear", env_rdy, 0);
    // R6: set wins over ack in the completion cycle
    push(16'd7);
    @(negedge clk); smp_vld = 1; smp_data = 16'd9; ack_w1c = 1; rd_strobe = 1;
    idle(1);
    check(env_rdy == 1'b1 && env_data == 16'd9, "R6 set wins", env_rdy, 1);
    // R4: gaps do not advance the pairing
    push(16'd50); idle(4); push(16'd60); idle(2);
    check(env_data == 16'd60, "R4 gap pairing", env_data, 60);
    push(16'd70); idle(2);
    check(env_data == 16'd60, "R4 hold on first", env_data, 60);
    // R8: clear mid-pair restarts pairing
    do_clr(); idle(1);
    check(env_data == 0 && !env_rdy, "R8 clear", env_data, 0);
    push(16'd11); push(16'd22); idle(1);
    check(env_data == 16'd22, "R8 phase restart", env_data, 22);
    // R8: clear wins over a sample
    @(negedge clk); smp_vld = 1; smp_data = 16'd300; clr = 1; idle(1);
    check(env_data == 0, "R8 clr priority", env_data, 0);

    // R3: smoothing with several shifts, sine-like and burst patterns
    for (int k = 1; k < 16; k += 3) begin
      shift_k = k[3:0];
      do_clr();
      for (int i = 0; i < 200; i++) begin
        push((i % 10 < 5) ? 16'd30000 : -16'sd30000);
        if (i % 7 == 0) idle(1);
      end
      for (int i = 0; i < 60; i++) push(16'h8000);
      idle(3);
    end

    // randomized traffic with collisions on completion cycles
    ph = 0;
    do_clr();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      smp_vld   = ($urandom % 3) != 0;
      smp_data  = 16'($urandom);
      if (i % 500 == 0) shift_k = 4'($urandom);
      irq_en    = ($urandom % 4) != 0;
      clr       = ($urandom % 200) == 0;
      rd_strobe = (smp_vld && ph == 1) ? ($urandom % 2) : (($urandom % 8) == 0);
      ack_w1c   = ($urandom % 10) == 0;
      if (clr) ph = 0;
      else if (smp_vld) ph = 1 - ph;
    end
    idle(5);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule